// File: doc/BRIEF.md
# Index Register X Store Sequencer

This block sequences one store-index-register-X instruction for a processor core whose index registers can be 8 or 16 bits wide. A start pulse delivers the opcode byte and up to two operand bytes. The block also samples the register file inputs on that same edge: X, Y, the direct page register, the data bank register and the index-width flag. It then works out the effective address for the selected addressing mode and counts off the cycles the instruction takes. In the closing cycles it drives one or two byte writes onto the memory bus.

The instruction length depends on three things: the addressing mode, the index width, and whether the low byte of the direct page register is zero. A surrounding core uses `busy` to hold off the next instruction and `done` to retire the current one. `cyc_cnt` exposes the cycle position so that timing can be compared against a reference table. Status flags pass through the block unchanged. An opcode outside the supported set is reported and causes no bus traffic.

Top module: `stx_seq`

## Requirements
- R1: After reset, `busy`, `done`, `bus_we` and `illegal` are 0 and `cyc_cnt` is 0.
- R2: Opcode 0x8E selects absolute mode with a base length of 4 cycles. Opcode 0x86 selects direct page mode with a base length of 3 cycles. Opcode 0x96 selects direct page indexed by Y with a base length of 4 cycles. Cycle k after the start edge shows `cyc_cnt` = k, and `done` is high only in the final cycle T.
- R3: When `idx8` is 0 (16-bit index), T is one cycle longer than the base length in every mode.
- R4: In the two direct page modes only, T grows by one more cycle when `dp_reg[7:0]` is nonzero. Absolute mode ignores the direct page register.
- R5: In absolute mode the effective address (EA) is {`dbank`, `op_hi`, `op_lo`}.
- R6: In direct page mode, EA is {8'h00, (`dp_reg` + `op_lo`) mod 2^16}.
- R7: In indexed mode, EA is {8'h00, (`dp_reg` + `op_lo` + Yeff) mod 2^16}. Yeff is {8'h00, `y_reg[7:0]`} when `idx8` = 1 and `y_reg` otherwise.
- R8: With `idx8` = 1 there is exactly one write, in cycle T, of `x_reg[7:0]` to EA.
- R9: With `idx8` = 0 there are exactly two writes. `x_reg[7:0]` goes to EA in cycle T-1, then `x_reg[15:8]` goes to EA+1 (a 24-bit sum) in cycle T.
- R10: `busy` is high in cycles 1..T and low in the cycle after T.
- R11: A start with any other opcode raises `illegal` for exactly the cycle after the start edge. No busy period follows and no write occurs.
- R12: `flags_out` always equals `flags_in`.
- R13: While `busy` is high, `start` is ignored. The running instruction keeps the opcode, operands and registers it captured at its own start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (sampled while idle) |
| opcode | input | 8 | Instruction opcode byte |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte (absolute mode only) |
| x_reg | input | 16 | X index register |
| y_reg | input | 16 | Y index register |
| dp_reg | input | 16 | Direct page register |
| dbank | input | 8 | Data bank register |
| idx8 | input | 1 | 1 = 8-bit index registers, 0 = 16-bit |
| flags_in | input | 8 | Processor status flags |
| flags_out | output | 8 | Status flags, unchanged |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| cyc_cnt | output | 4 | Cycle position within the instruction, 0 when idle |
| bus_addr | output | 24 | Write address |
| bus_wdata | output | 8 | Write data byte |
| bus_we | output | 1 | Write strobe |
| illegal | output | 1 | Unsupported opcode seen |

## Verification
All results are counted from the clock edge that captures `start`. `cyc_cnt` reads k in cycle k. The write strobes fall in cycles T-1 and T, or in cycle T alone. `done` falls in cycle T, and `busy` drops in cycle T+1. `illegal` is due only in cycle 1. The bench drives inputs on falling edges and samples every output at each following falling edge. It logs the cycle number of every strobe and of `done`. These are compared with T computed from the mode, the width and the direct page low byte, so a write or completion that comes one cycle early or late fails.

// File: rtl/stx_pkg.sv
// Shared types and decode helpers for the index-register store sequencer.
// Assumes opcodes are full 8-bit bytes; unknown opcodes map to AM_NONE.
package stx_pkg;

    typedef enum logic [1:0] {
        AM_ABS  = 2'd0,
        AM_DP   = 2'd1,
        AM_DPY  = 2'd2,
        AM_NONE = 2'd3
    } addr_mode_t;

    localparam logic [7:0] OPC_ABS = 8'h8E;
    localparam logic [7:0] OPC_DP  = 8'h86;
    localparam logic [7:0] OPC_DPY = 8'h96;

    // Map an opcode byte to its addressing mode.
    function automatic addr_mode_t decode_mode(input logic [7:0] opc);
        case (opc)
            OPC_ABS: decode_mode = AM_ABS;
            OPC_DP:  decode_mode = AM_DP;
            OPC_DPY: decode_mode = AM_DPY;
            default: decode_mode = AM_NONE;
        endcase
    endfunction

    // Base cycle count of a mode before penalties.
    function automatic logic [3:0] base_cycles(input addr_mode_t m);
        case (m)
            AM_ABS:  base_cycles = 4'd4;
            AM_DP:   base_cycles = 4'd3;
            AM_DPY:  base_cycles = 4'd4;
            default: base_cycles = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/stx_ea_calc.sv
// Effective address generator. Purely combinational.
// Assumes direct page forms live in bank 0 and wrap at 16 bits.
module stx_ea_calc
    import stx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  addr_mode_t        mode,
    input  logic [BYTE_W-1:0] op_lo,
    input  logic [BYTE_W-1:0] op_hi,
    input  logic [REG_W-1:0]  dp_reg,
    input  logic [REG_W-1:0]  y_reg,
    input  logic [BYTE_W-1:0] dbank,
    input  logic              idx8,
    output logic [ADDR_W-1:0] ea
);
    localparam int BANK_W = ADDR_W - REG_W;

    logic [REG_W-1:0] y_eff;
    logic [REG_W-1:0] dp_sum;
    logic [REG_W-1:0] dpy_sum;

    // Narrow Y to its low byte in 8-bit index mode.
    always_comb begin
        y_eff = idx8 ? {{(REG_W-BYTE_W){1'b0}}, y_reg[BYTE_W-1:0]} : y_reg;
    end

    // Direct page sums, wrapping within 16 bits.
    always_comb begin
        dp_sum  = dp_reg + {{(REG_W-BYTE_W){1'b0}}, op_lo};
        dpy_sum = dp_sum + y_eff;
    end

    // Select the address for the mode.
    always_comb begin
        case (mode)
            AM_ABS:  ea = {dbank[BANK_W-1:0], op_hi, op_lo};
            AM_DP:   ea = {{BANK_W{1'b0}}, dp_sum};
            AM_DPY:  ea = {{BANK_W{1'b0}}, dpy_sum};
            default: ea = '0;
        endcase
    end
endmodule

// File: rtl/stx_cycle_ctl.sv
// Cycle counter for one instruction: counts 1..total, flags the last cycle.
// Assumes total >= 2 whenever launch is asserted; launch is ignored while busy.
module stx_cycle_ctl #(
    parameter int CNT_W   = 4,
    parameter int MAX_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [CNT_W-1:0] total,
    output logic             busy,
    output logic             last,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] total_q
);
    // Advance the counter and latch the length at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            total_q <= '0;
        end else if (cnt == '0) begin
            if (launch) begin
                cnt     <= CNT_W'(1);
                total_q <= total;
            end
        end else if (cnt == total_q) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign busy = (cnt != '0);
    assign last = busy && (cnt == total_q);

    // R10: counter steps by one through the instruction
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !last |=> cnt == $past(cnt) + CNT_W'(1));

    // R10: completion returns to idle
    a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);

    // R2: count never exceeds the longest instruction
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_CYC));
endmodule

// File: rtl/stx_seq.sv
// Top of the store-index-X sequencer: decodes, captures operands at start,
// times the instruction and drives the byte write bus in its final cycles.
// Assumes a single-cycle start pulse while idle; flags are never modified.
module stx_seq
    import stx_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int REG_W   = 16,
    parameter int BYTE_W  = 8,
    parameter int CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] opcode,
    input  logic [BYTE_W-1:0] op_lo,
    input  logic [BYTE_W-1:0] op_hi,
    input  logic [REG_W-1:0]  x_reg,
    input  logic [REG_W-1:0]  y_reg,
    input  logic [REG_W-1:0]  dp_reg,
    input  logic [BYTE_W-1:0] dbank,
    input  logic              idx8,
    input  logic [BYTE_W-1:0] flags_in,
    output logic [BYTE_W-1:0] flags_out,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  cyc_cnt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              illegal
);
    localparam int MAX_CYC = 6;

    addr_mode_t        mode_d;
    logic              legal_d;
    logic [CNT_W-1:0]  total_d;
    logic [ADDR_W-1:0] ea_d;
    logic              launch;

    logic [ADDR_W-1:0] ea_q;
    logic [REG_W-1:0]  x_q;
    logic              wide_q;
    logic [CNT_W-1:0]  total_q;
    logic              first_wr;
    logic              last_wr;

    // Decode the opcode and compute the instruction length.
    always_comb begin
        mode_d  = decode_mode(opcode);
        legal_d = (mode_d != AM_NONE);
        total_d = base_cycles(mode_d)
                + (idx8 ? CNT_W'(0) : CNT_W'(1))
                + (((mode_d == AM_DP) || (mode_d == AM_DPY)) && (dp_reg[BYTE_W-1:0] != '0)
                   ? CNT_W'(1) : CNT_W'(0));
    end

    stx_ea_calc #(
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W),
        .BYTE_W (BYTE_W)
    ) ea_i (
        .mode   (mode_d),
        .op_lo  (op_lo),
        .op_hi  (op_hi),
        .dp_reg (dp_reg),
        .y_reg  (y_reg),
        .dbank  (dbank),
        .idx8   (idx8),
        .ea     (ea_d)
    );

    assign launch = start && !busy && legal_d;

    stx_cycle_ctl #(
        .CNT_W   (CNT_W),
        .MAX_CYC (MAX_CYC)
    ) ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .total   (total_d),
        .busy    (busy),
        .last    (done),
        .cnt     (cyc_cnt),
        .total_q (total_q)
    );

    // Capture address, data and width at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q   <= '0;
            x_q    <= '0;
            wide_q <= 1'b0;
        end else if (launch) begin
            ea_q   <= ea_d;
            x_q    <= x_reg;
            wide_q <= !idx8;
        end
    end

    // Flag an unsupported opcode for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal <= 1'b0;
        else        illegal <= start && !busy && !legal_d;
    end

    // Place the write cycles at the end of the instruction.
    always_comb begin
        first_wr  = busy && wide_q && (cyc_cnt == total_q - CNT_W'(1));
        last_wr   = done;
        bus_we    = first_wr || last_wr;
        bus_addr  = (last_wr && wide_q) ? ea_q + ADDR_W'(1) : ea_q;
        if (last_wr && wide_q) bus_wdata = x_q[REG_W-1:BYTE_W];
        else                   bus_wdata = x_q[BYTE_W-1:0];
        if (!bus_we) begin
            bus_addr  = '0;
            bus_wdata = '0;
        end
    end

    assign flags_out = flags_in;

    // R8: in 8-bit mode the only write is in the final cycle
    a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && !wide_q |-> done);

    // R9: in 16-bit mode a write in the final cycle follows one the cycle before
    a_r9_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && !done |=> bus_we && done);

    // R10: writes happen only during an instruction
    a_r10_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> busy);

    // R11: an illegal opcode brings no busy period and no write
    a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !busy && !bus_we);

    // R13: length is held steady through a running instruction
    a_r13_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(total_q));
endmodule

// File: tb/stx_seq_tb.sv
// Directed bench for stx_seq: one task per scenario, each checking itself.
module stx_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  op_lo = 8'h00;
    logic [7:0]  op_hi = 8'h00;
    logic [15:0] x_reg = 16'h0;
    logic [15:0] y_reg = 16'h0;
    logic [15:0] dp_reg = 16'h0;
    logic [7:0]  dbank = 8'h00;
    logic        idx8 = 1'b1;
    logic [7:0]  flags_in = 8'h00;
    logic [7:0]  flags_out;
    logic        busy, done, bus_we, illegal;
    logic [3:0]  cyc_cnt;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    stx_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_lo(op_lo), .op_hi(op_hi), .x_reg(x_reg), .y_reg(y_reg),
        .dp_reg(dp_reg), .dbank(dbank), .idx8(idx8), .flags_in(flags_in),
        .flags_out(flags_out), .busy(busy), .done(done), .cyc_cnt(cyc_cnt),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference instruction length.
    function automatic int ref_len(input logic [7:0] opc, input logic i8,
                                   input logic [15:0] dp);
        int n;
        case (opc)
            8'h8E: n = 4;
            8'h86: n = 3;
            8'h96: n = 4;
            default: n = 0;
        endcase
        if (!i8) n++;
        if ((opc == 8'h86 || opc == 8'h96) && dp[7:0] != 8'h00) n++;
        return n;
    endfunction

    // Reference effective address.
    function automatic logic [23:0] ref_ea(input logic [7:0] opc, input logic [7:0] lo,
        input logic [7:0] hi, input logic [15:0] dp, input logic [15:0] y,
        input logic [7:0] db, input logic i8);
        logic [15:0] s;
        if (opc == 8'h8E) return {db, hi, lo};
        s = dp + {8'h00, lo};
        if (opc == 8'h96) s = s + (i8 ? {8'h00, y[7:0]} : y);
        return {8'h00, s};
    endfunction

    // Run one instruction and check timing, writes and addresses.
    task automatic run_store(input string req, input logic [7:0] opc,
        input logic [7:0] lo, input logic [7:0] hi, input logic [15:0] x,
        input logic [15:0] y, input logic [15:0] dp, input logic [7:0] db,
        input logic i8, input bit poke);
        int t;
        logic [23:0] ea;
        int nwr, done_at, busy_bad, cnt_bad;
        logic [23:0] wa [2];
        logic [7:0]  wd [2];
        int          wc [2];
        t  = ref_len(opc, i8, dp);
        ea = ref_ea(opc, lo, hi, dp, y, db, i8);
        nwr = 0; done_at = 0; busy_bad = 0; cnt_bad = 0;
        @(negedge clk);
        opcode = opc; op_lo = lo; op_hi = hi; x_reg = x; y_reg = y;
        dp_reg = dp; dbank = db; idx8 = i8; start = 1'b1;
        for (int k = 1; k <= t + 1; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (k == 1) begin
                // scramble every input after capture
                opcode = 8'h86; op_lo = ~lo; op_hi = ~hi; x_reg = ~x;
                y_reg = ~y; dp_reg = ~dp; dbank = ~db; idx8 = ~i8;
            end
            if (poke && k == 2) start = 1'b1;
            if (k <= t) begin
                if (!busy) busy_bad++;
                if (cyc_cnt != 4'(k)) cnt_bad++;
            end else if (busy) busy_bad++;
            if (done) done_at = k;
            if (bus_we) begin
                if (nwr < 2) begin wa[nwr] = bus_addr; wd[nwr] = bus_wdata; wc[nwr] = k; end
                nwr++;
            end
        end
        start = 1'b0;
        check(done_at == t, req, "done cycle", done_at, t);
        check(busy_bad == 0 && cnt_bad == 0, "R10", "busy/cyc_cnt mismatches",
              busy_bad + cnt_bad, 0);
        if (i8) begin
            check(nwr == 1, "R8", "write count", nwr, 1);
            if (nwr >= 1) begin
                check(wc[0] == t, "R8", "write cycle", wc[0], t);
                check(wa[0] == ea, req, "write addr", wa[0], ea);
                check(wd[0] == x[7:0], "R8", "write data", wd[0], x[7:0]);
            end
        end else begin
            check(nwr == 2, "R9", "write count", nwr, 2);
            if (nwr >= 2) begin
                check(wc[0] == t - 1 && wc[1] == t, "R9", "write cycles",
                      wc[0] * 16 + wc[1], (t - 1) * 16 + t);
                check(wa[0] == ea, req, "low addr", wa[0], ea);
                check(wa[1] == ea + 24'd1, "R9", "high addr", wa[1], ea + 24'd1);
                check(wd[0] == x[7:0] && wd[1] == x[15:8], "R9", "data pair",
                      {wd[0], wd[1]}, {x[7:0], x[15:8]});
            end
        end
        @(negedge clk);
        if (poke) check(!busy, "R13", "start during busy relaunched", busy, 0);
    endtask

    // Unsupported opcode: one-cycle flag, no activity.
    task automatic run_illegal(input logic [7:0] opc);
        int act;
        @(negedge clk);
        opcode = opc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(illegal && !busy && !bus_we, "R11", "flag cycle",
              {illegal, busy, bus_we}, 3'b100);
        act = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (illegal || busy || bus_we) act++;
        end
        check(act == 0, "R11", "later activity", act, 0);
    endtask

    // Flag pass-through under changing patterns.
    task automatic run_flags();
        int bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            flags_in = 8'(i * 37 + 5);
            #1;
            if (flags_out != flags_in) bad++;
        end
        check(bad == 0, "R12", "flag mismatches", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !bus_we && !illegal && cyc_cnt == 4'd0, "R1",
              "reset outputs", {busy, done, bus_we, illegal, cyc_cnt}, 0);
        rst_n = 1'b1;
        // absolute, both widths; dp low byte must not matter (R4)
        run_store("R5", 8'h8E, 8'h34, 8'h12, 16'hBEEF, 16'h0, 16'h0000, 8'h7E, 1'b1, 1'b0);
        run_store("R4", 8'h8E, 8'h34, 8'h12, 16'hBEEF, 16'h0, 16'h00FF, 8'h7E, 1'b1, 1'b0);
        run_store("R3", 8'h8E, 8'hFF, 8'hFF, 16'hA55A, 16'h0, 16'h0001, 8'h12, 1'b0, 1'b0);
        // direct page
        run_store("R2", 8'h86, 8'h10, 8'h00, 16'h0042, 16'h0, 16'h0300, 8'h55, 1'b1, 1'b0);
        run_store("R4", 8'h86, 8'h10, 8'h00, 16'h1142, 16'h0, 16'h0301, 8'h55, 1'b1, 1'b0);
        run_store("R6", 8'h86, 8'h20, 8'h00, 16'hC3D4, 16'h0, 16'hFFF0, 8'h55, 1'b0, 1'b0);
        // indexed
        run_store("R7", 8'h96, 8'h05, 8'h00, 16'h0077, 16'h1234, 16'h0200, 8'h00, 1'b1, 1'b0);
        run_store("R7", 8'h96, 8'hF0, 8'h00, 16'h8899, 16'hFFF0, 16'h0081, 8'h00, 1'b0, 1'b0);
        // start while busy is ignored
        run_store("R13", 8'h96, 8'h01, 8'h00, 16'h3C3C, 16'h0002, 16'h1000, 8'h00, 1'b0, 1'b1);
        run_illegal(8'hEA);
        run_illegal(8'h8C);
        run_flags();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule